// File: doc/BRIEF.md
# Six-Channel DAC Sample Mute Controller

This block sits in the sample path of a six-channel audio DAC. For each channel it decides when output samples are forced to zero. One control byte sets the manual mute of each channel. It also sets whether long runs of zero samples mute a channel, and whether mute and volume changes wait for a zero crossing of the signal or take effect on the next sample.

Each channel has a signed sample word, and all six channels share one valid strobe. A volume-change request for a channel is held pending. It is released as a one-cycle apply pulse on the same sample where a pending mute change would land. The volume arithmetic is done downstream on that pulse. A change that is waiting for a crossing is forced through after a bounded number of samples, so that a DC signal cannot hold it off.

Top module: `dac_mute_ctrl`

## Requirements
- R1: After reset the control byte holds 0x3F. All six channels are muted, zero-crossing timing is enabled and zero-run muting is armed. `mute_o` reads 0x3F, and `smp_valid_o` and `vol_apply_o` read 0.
- R2: Control bits 0 to 5 are the manual mute requests for channels 1 to 6, with channel 1 in bit 0. A 1 mutes the channel. Every output sample of a muted channel is zero, and an unmuted channel passes its input sample unchanged. Outputs appear one cycle after the input sample, with `smp_valid_o` high.
- R3: When bit 7 is 1, a changed manual mute bit takes effect on the next valid sample, whatever that sample's value.
- R4: When bit 7 is 0, a changed manual mute bit takes effect only on a valid sample that is exactly zero or whose sign bit differs from the previous valid sample on that channel. Before the first sample after reset, the previous sign is taken as positive.
- R5: A pulse on `vol_req_i` marks a volume change pending for that channel. The change is released under the same timing rule as mute changes, as a one-cycle `vol_apply_o` pulse that comes out with the output sample on which it lands.
- R6: A change still pending after 1023 valid samples without a crossing is forced through on the 1024th valid sample.
- R7: When bit 6 is 0, a channel becomes muted on the 512th consecutive zero sample. The zero-run count saturates at 512, and a later write that clears bit 6 mutes a channel whose run is already saturated.
- R8: A zero-run mute is released on the first non-zero valid sample, and that sample is passed through unless the channel is muted manually.
- R9: When bit 6 is 1, runs of zero samples never mute a channel.
- R10: A write that turns bit 7 from 0 to 1 while a change is pending applies that change on the next valid sample, even when that sample is not a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| smp_valid_i | input | 1 | Input sample strobe shared by all channels |
| smp_data_i | input | 6*SMP_W | Signed input samples, channel 1 in the low word |
| vol_req_i | input | 6 | Per-channel volume-change request pulses |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_data_o | output | 6*SMP_W | Output samples after muting |
| mute_o | output | 6 | Effective mute per channel, manual or zero-run |
| vol_apply_o | output | 6 | One-cycle volume-apply pulse per channel |

## Verification
The assertions assume that a control write and a volume request never fall in the same cycle as a valid sample, so each sample sees one settled control byte and one settled set of pending requests. They also assume that bit 6 does not change between a sample and the cycle in which its result is checked. The stimulus keeps writes, request pulses and samples in separate cycles and deasserts the valid strobe between samples. The run-length and timeout tests hold the channel sign constant, so that no crossing can hide the counter boundary.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int NCH = 6;
  localparam logic [7:0] CTRL_RST = 8'h3F;

  typedef struct packed {
    logic           zc_off;     // bit 7: apply changes without waiting for a crossing
    logic           zmute_off;  // bit 6: zero runs never mute
    logic [NCH-1:0] mute;       // bits 5..0: manual mute, channel 1 in bit 0
  } ctrl_t;
endpackage

// File: rtl/dm_ctrl_reg.sv
module dm_ctrl_reg
  import dm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= ctrl_t'(CTRL_RST);
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/dm_zero_run.sv
module dm_zero_run #(
  parameter int ZRUN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic is_zero_i,
  input  logic off_i,
  output logic auto_q_o,
  output logic auto_d_o
);
  localparam int RW = $clog2(ZRUN + 1);
  localparam logic [RW-1:0] RMAX = RW'(ZRUN);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (valid_i) begin
      if (!is_zero_i)        run_d = '0;
      else if (run_q != RMAX) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign auto_q_o = (run_q == RMAX) & ~off_i;
  assign auto_d_o = (run_d == RMAX) & ~off_i;

  AST_RUN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RMAX); // R7
  AST_RUN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_zero_i |=> !auto_q_o); // R8
endmodule

// File: rtl/dm_chan.sv
module dm_chan #(
  parameter int SMP_W = 16,
  parameter int ZRUN  = 512,
  parameter int TMO   = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             mute_req_i,
  input  logic             zc_off_i,
  input  logic             zmute_off_i,
  input  logic             vol_req_i,
  output logic [SMP_W-1:0] data_o,
  output logic             mute_o,
  output logic             vol_apply_o
);
  localparam int WW = $clog2(TMO);
  localparam logic [WW-1:0] WLAST = WW'(TMO - 1);

  logic             mute_app_q, mute_app_d;
  logic             vol_pend_q;
  logic             prev_sgn_q;
  logic [WW-1:0]    wait_q;
  logic             is_zero, sgn, zc, tmo, go, pending;
  logic             auto_q, auto_d;

  assign is_zero = (data_i == '0);
  assign sgn     = data_i[SMP_W-1];
  assign zc      = is_zero | (sgn != prev_sgn_q);
  assign tmo     = (wait_q == WLAST);
  assign pending = (mute_req_i != mute_app_q) | vol_pend_q;
  assign go      = valid_i & (zc_off_i | zc | tmo);
  assign mute_app_d = go ? mute_req_i : mute_app_q;

  dm_zero_run #(.ZRUN(ZRUN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .is_zero_i (is_zero),
    .off_i     (zmute_off_i),
    .auto_q_o  (auto_q),
    .auto_d_o  (auto_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_app_q  <= 1'b1;
      vol_pend_q  <= 1'b0;
      prev_sgn_q  <= 1'b0;
      wait_q      <= '0;
      data_o      <= '0;
      vol_apply_o <= 1'b0;
    end else begin
      mute_app_q  <= mute_app_d;
      vol_pend_q  <= (vol_pend_q & ~go) | vol_req_i;
      vol_apply_o <= go & vol_pend_q;
      if (valid_i) begin
        prev_sgn_q <= sgn;
        wait_q     <= (pending && !go) ? wait_q + 1'b1 : '0;
        data_o     <= (mute_app_d | auto_d) ? '0 : data_i;
      end
    end
  end

  assign mute_o = mute_app_q | auto_q;

  AST_MUTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mute_req_i && zc_off_i |=> data_o == '0); // R2
  AST_ZC_OFF_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && zc_off_i |=> mute_app_q == $past(mute_req_i)); // R3
  AST_HOLD_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !zc_off_i && !is_zero && sgn == prev_sgn_q && !tmo
    |=> $stable(mute_app_q)); // R4
  AST_VOL_FROM_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_apply_o |-> $past(vol_pend_q) && $past(valid_i)); // R5
  AST_WAIT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && tmo |=> wait_q == '0); // R6
endmodule

// File: rtl/dac_mute_ctrl.sv
module dac_mute_ctrl
  import dm_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ZRUN  = 512,
  parameter int TMO   = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [7:0]           cfg_wdata_i,
  input  logic                 smp_valid_i,
  input  logic [NCH*SMP_W-1:0] smp_data_i,
  input  logic [NCH-1:0]       vol_req_i,
  output logic                 smp_valid_o,
  output logic [NCH*SMP_W-1:0] smp_data_o,
  output logic [NCH-1:0]       mute_o,
  output logic [NCH-1:0]       vol_apply_o
);
  ctrl_t ctrl;

  dm_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (ctrl)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dm_chan #(.SMP_W(SMP_W), .ZRUN(ZRUN), .TMO(TMO)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (smp_valid_i),
      .data_i      (smp_data_i[g*SMP_W +: SMP_W]),
      .mute_req_i  (ctrl.mute[g]),
      .zc_off_i    (ctrl.zc_off),
      .zmute_off_i (ctrl.zmute_off),
      .vol_req_i   (vol_req_i[g]),
      .data_o      (smp_data_o[g*SMP_W +: SMP_W]),
      .mute_o      (mute_o[g]),
      .vol_apply_o (vol_apply_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_valid_o <= 1'b0;
    else         smp_valid_o <= smp_valid_i;
  end

  AST_APPLY_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |vol_apply_o |-> smp_valid_o); // R5
endmodule

// File: tb/dac_mute_ctrl_tb.sv
module dac_mute_ctrl_tb;
  localparam int NCH = 6, W = 16, ZRUN = 512, TMO = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           we = 1'b0, valid = 1'b0;
  logic [7:0]     wd = '0;
  logic [NCH*W-1:0] din = '0;
  logic [NCH-1:0] vreq_in = '0;
  logic           vo;
  logic [NCH*W-1:0] dout;
  logic [NCH-1:0] mo, vao;

  dac_mute_ctrl #(.SMP_W(W), .ZRUN(ZRUN), .TMO(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .smp_valid_i(valid), .smp_data_i(din), .vol_req_i(vreq_in),
    .smp_valid_o(vo), .smp_data_o(dout), .mute_o(mo), .vol_apply_o(vao));

  typedef struct {
    logic [NCH*W-1:0] d;
    logic [NCH-1:0]   m;
    logic [NCH-1:0]   v;
    string            tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  logic [7:0]     m_ctrl = 8'h3F;
  logic [NCH-1:0] m_app = '1, m_vp = '0;
  logic           m_prev [NCH];
  int             m_run [NCH], m_wait [NCH];

  initial for (int c = 0; c < NCH; c++) begin
    m_prev[c] = 1'b0; m_run[c] = 0; m_wait[c] = 0;
  end

  function automatic logic [NCH*W-1:0] fill(input logic [W-1:0] v);
    logic [NCH*W-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*W +: W] = v;
    return r;
  endfunction

  task automatic send(input logic [NCH*W-1:0] v);
    exp_t e;
    @(posedge clk); #1;
    valid = 1'b1; din = v;
    e.tag = tag; e.v = '0; e.m = '0; e.d = '0;
    for (int c = 0; c < NCH; c++) begin
      logic [W-1:0] s;
      logic zero, zc, pend, go, mute;
      s    = v[c*W +: W];
      zero = (s == '0);
      zc   = zero || (s[W-1] != m_prev[c]);
      pend = (m_ctrl[c] != m_app[c]) || m_vp[c];
      go   = m_ctrl[7] || zc || (m_wait[c] == TMO-1);
      e.v[c] = go && m_vp[c];
      if (go) begin m_app[c] = m_ctrl[c]; m_vp[c] = 1'b0; end
      m_wait[c] = (pend && !go) ? m_wait[c] + 1 : 0;
      m_run[c]  = zero ? ((m_run[c] == ZRUN) ? ZRUN : m_run[c] + 1) : 0;
      m_prev[c] = s[W-1];
      mute = m_app[c] || (m_run[c] == ZRUN && !m_ctrl[6]);
      e.m[c] = mute;
      e.d[c*W +: W] = mute ? '0 : s;
    end
    sb.push_back(e);
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(posedge clk); #1; we = 1'b1; wd = b;
    @(posedge clk); #1; we = 1'b0;
    m_ctrl = b;
  endtask

  task automatic vreq(input logic [NCH-1:0] mk);
    @(posedge clk); #1; vreq_in = mk;
    @(posedge clk); #1; vreq_in = '0;
    m_vp |= mk;
  endtask

  // monitor: compare each output sample with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && vo) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected output sample act=%h exp=none", dout);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (dout !== e.d || mo !== e.m || vao !== e.v) begin
          n_fail++;
          $display("FAIL %s data act=%h exp=%h mute act=%h exp=%h vol act=%h exp=%h",
                   e.tag, dout, e.d, mo, e.m, vao, e.v);
        end
      end
    end
  end

  task automatic finish_run();
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing outputs act=%0d exp=0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NCH*W-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (mo !== 6'h3F || vo !== 1'b0 || vao !== '0) begin
      n_fail++;
      $display("FAIL R1 reset mute act=%h exp=3f valid act=%b vol act=%h", mo, vo, vao);
    end

    tag = "R1"; send(fill(16'd100));
    tag = "R3"; wr(8'h80); send(fill(16'd100));
    tag = "R2"; wr(8'h85); send(fill(16'd200));
    wr(8'hA0); send(fill(-16'sd5));

    tag = "R4"; wr(8'h00);
    send(fill(-16'sd7));
    send(fill(16'd9));
    wr(8'h01); send(fill(16'd12));
    v = fill(16'd12); v[0 +: W] = '0; send(v);

    tag = "R5"; vreq(6'h3F);
    send(fill(16'd15));
    send(fill(-16'sd15));

    tag = "R6"; wr(8'h00); vreq(6'h02);
    for (int i = 0; i < TMO; i++) send(fill(-16'sd15));
    send(fill(-16'sd15));

    tag = "R10"; wr(8'h04); send(fill(-16'sd3));
    wr(8'h84); send(fill(-16'sd3));

    tag = "R7"; wr(8'h80);
    v = fill(16'd50); v[0 +: W] = '0;
    for (int i = 0; i < ZRUN + 2; i++) send(v);
    tag = "R8"; send(fill(16'd50));

    tag = "R9"; wr(8'hC0);
    v = fill(16'd50); v[W +: W] = '0;
    for (int i = 0; i < ZRUN + 88; i++) send(v);
    tag = "R7"; wr(8'h80); send(v);
    tag = "R8"; send(fill(-16'sd2));

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule